// File: doc/BRIEF.md
# Sixteen-Bit Fixed-Point DSP ALU

This block is the arithmetic and logic unit of a fixed-point signal processor. Each clock cycle it accepts two 16-bit operands, a 4-bit operation code, a 4-bit constant bit index and an external carry. It registers a 16-bit result and five status flags: zero, negative, carry, overflow and quotient bit. Every operation settles in a single cycle.

The operation set covers the following:

- Add and subtract, each with or without the carry input. Chaining the carry lets software build arithmetic wider than one word.
- Four logic operations.
- Set, clear, toggle and test of one bit, chosen by a constant index.
- Pass and two's-complement negate.
- Two one-step division primitives, one unsigned and one signed. Software issues a division step once per cycle. It feeds each new dividend bit through the carry input and collects the quotient bit from the flag output.

A result-free mode updates the flags but leaves the result register as it was. This suits compare-style use.

Top module: `dsp_alu16`

## Requirements
- R1: After reset is asserted (rstN low), result and all five flags read 0.
- R2: Opcode 0 (add) returns x+y and opcode 1 (add with carry) returns x+y+carryIn. The carry flag is the carry out of bit 15. The overflow flag is set when x and y share a sign and the result's sign differs from it.
- R3: Opcode 2 (subtract) returns x-y and opcode 3 (subtract with borrow) returns x+~y+carryIn. The carry flag is 1 when no borrow occurs. The overflow flag is set when x and y differ in sign and the result's sign differs from x's sign.
- R4: Logic opcodes are 4 AND, 5 OR, 6 XOR and 7 NOT x. Each returns the bitwise value and clears the carry, overflow and quotient flags.
- R5: With mask = 1<<bitSel, the bit opcodes are 8 set (x|mask), 9 clear (x&~mask), 10 toggle (x^mask) and 11 test (x&mask). Test therefore raises the zero flag exactly when the selected bit is clear. All four clear carry and overflow.
- R6: Opcode 12 is the unsigned division step. It forms w = {x, carryIn} as 17 bits. If w >= y, the result is w-y and the quotient bit is 1. Otherwise the result is w[15:0] and the quotient bit is 0. The carry flag equals the quotient bit. Sixteen steps that start from a remainder of 0 and feed the dividend MSB first yield the quotient and the remainder.
- R7: Opcode 13 is the signed division step. It forms t = {x[14:0], carryIn}. If the signs of x and y match, the result is t-y; otherwise it is t+y. The quotient bit is 1 when the sign of the result equals the sign of y. The carry flag equals the quotient bit.
- R8: The zero flag shows that the operation's value is 0. The negative flag is bit 15 of that value. Both follow the value even when it is not written.
- R9: While en is low, the result and all flags hold.
- R10: When en is high and noWrite is high, the flags update and the result holds.
- R11: An add followed by an add-with-carry, with the first carry fed in, gives a correct 32-bit sum. The same holds for subtract followed by subtract-with-borrow.
- R12: Outputs change only at the rising clock edge after the inputs are presented. They carry the new values from that edge on.
- R13: Opcode 14 passes x unchanged and clears carry and overflow. Opcode 15 returns 0-x. Its carry is set only for x=0, and its overflow is set only for x=0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation enable |
| noWrite | input | 1 | Result-free mode: update the flags only |
| opCode | input | 4 | Operation select |
| bitSel | input | 4 | Constant bit index for the bit operations |
| xOp | input | 16 | First operand, or partial remainder for division |
| yOp | input | 16 | Second operand, or divisor |
| carryIn | input | 1 | Carry in, or next dividend bit for division |
| result | output | 16 | Registered result |
| zeroFlag | output | 1 | Value is zero |
| negFlag | output | 1 | Value bit 15 |
| carryFlag | output | 1 | Carry out / no-borrow / quotient bit |
| ovfFlag | output | 1 | Signed overflow |
| quotFlag | output | 1 | Quotient bit of the last division step |

## Verification
Every result and flag is due at the first rising edge after its inputs are applied, with exactly one register between input and output. The bench changes inputs on the falling edge and compares on the next falling edge, half a cycle after the capturing edge. It also reads the outputs once just before that edge to confirm they have not yet moved. Multi-step division and the 32-bit carry chains feed each step's registered result back as the next operand. Each stage is therefore checked one cycle later, in sequence.

// File: rtl/dsp_alu16_pkg.sv
package dsp_alu16_pkg;

  localparam int ALU_W = 16;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_BSET = 4'd8,
    OP_BCLR = 4'd9,
    OP_BTGL = 4'd10,
    OP_BTST = 4'd11,
    OP_DIVU = 4'd12,
    OP_DIVS = 4'd13,
    OP_PASS = 4'd14,
    OP_NEG  = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_ADDER,
    SEL_LOGIC,
    SEL_BIT,
    SEL_DIVU,
    SEL_DIVS,
    SEL_PASS
  } res_sel_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_EXT
  } cin_mode_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NOT
  } logic_op_e;

  typedef enum logic [1:0] {
    BT_SET,
    BT_CLR,
    BT_TGL,
    BT_TST
  } bit_op_e;

  typedef struct packed {
    logic             wrFlags;
    logic             wrResult;
    res_sel_e         resSel;
    logic             zeroA;
    logic             bFromX;
    logic             invB;
    cin_mode_e        cinMode;
    logic_op_e        logicOp;
    bit_op_e          bitOp;
    logic [ALU_W-1:0] bitMask;
  } alu_ctrl_t;

endpackage

// File: rtl/dsp_alu16_ctrl.sv
module dsp_alu16_ctrl
  import dsp_alu16_pkg::*;
#(
  parameter int WIDTH = ALU_W,
  localparam int SELW = $clog2(WIDTH)
) (
  input  logic            en,
  input  logic            noWrite,
  input  logic [3:0]      opCode,
  input  logic [SELW-1:0] bitSel,
  output alu_ctrl_t       ctrl
);

  logic [WIDTH-1:0] maskVec;

  // one-hot mask, one comparator per bit position
  for (genvar g = 0; g < WIDTH; g++) begin : gMask
    assign maskVec[g] = (bitSel == SELW'(g));
  end

  always_comb begin
    ctrl          = '0;
    ctrl.wrFlags  = en;
    ctrl.wrResult = en & ~noWrite;
    ctrl.resSel   = SEL_ADDER;
    ctrl.cinMode  = CIN_ZERO;
    ctrl.logicOp  = LG_AND;
    ctrl.bitOp    = BT_SET;
    ctrl.bitMask  = maskVec;
    case (alu_op_e'(opCode))
      OP_ADD:  ctrl.resSel = SEL_ADDER;
      OP_ADDC: ctrl.cinMode = CIN_EXT;
      OP_SUB: begin
        ctrl.invB    = 1'b1;
        ctrl.cinMode = CIN_ONE;
      end
      OP_SUBC: begin
        ctrl.invB    = 1'b1;
        ctrl.cinMode = CIN_EXT;
      end
      OP_AND: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_AND;
      end
      OP_OR: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_OR;
      end
      OP_XOR: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_XOR;
      end
      OP_NOT: begin
        ctrl.resSel  = SEL_LOGIC;
        ctrl.logicOp = LG_NOT;
      end
      OP_BSET: begin
        ctrl.resSel = SEL_BIT;
        ctrl.bitOp  = BT_SET;
      end
      OP_BCLR: begin
        ctrl.resSel = SEL_BIT;
        ctrl.bitOp  = BT_CLR;
      end
      OP_BTGL: begin
        ctrl.resSel = SEL_BIT;
        ctrl.bitOp  = BT_TGL;
      end
      OP_BTST: begin
        ctrl.resSel = SEL_BIT;
        ctrl.bitOp  = BT_TST;
      end
      OP_DIVU: ctrl.resSel = SEL_DIVU;
      OP_DIVS: ctrl.resSel = SEL_DIVS;
      OP_PASS: ctrl.resSel = SEL_PASS;
      OP_NEG: begin
        ctrl.zeroA   = 1'b1;
        ctrl.bFromX  = 1'b1;
        ctrl.invB    = 1'b1;
        ctrl.cinMode = CIN_ONE;
      end
      default: ctrl.resSel = SEL_ADDER;
    endcase
  end

endmodule

// File: rtl/dsp_alu16_dp.sv
module dsp_alu16_dp
  import dsp_alu16_pkg::*;
#(
  parameter int WIDTH = ALU_W,
  localparam int MSB = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  alu_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] xOp,
  input  logic [WIDTH-1:0] yOp,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             carryFlag,
  output logic             ovfFlag,
  output logic             quotFlag
);

  logic [WIDTH-1:0] addA, addB, bSrc;
  logic             cinBit;
  logic [WIDTH:0]   sum;
  logic             addOvf;
  logic [WIDTH-1:0] logicVal, bitVal;
  logic [WIDTH:0]   divWide;
  logic             divGe;
  logic [WIDTH-1:0] divUVal;
  logic [WIDTH-1:0] divShift, divSVal;
  logic             divSQ;
  logic [WIDTH-1:0] nextVal;
  logic             nextC, nextV, nextQ;

  // shared adder for add, subtract and negate
  always_comb begin
    bSrc = ctrl.bFromX ? xOp : yOp;
    addA = ctrl.zeroA ? '0 : xOp;
    addB = ctrl.invB ? ~bSrc : bSrc;
    case (ctrl.cinMode)
      CIN_ONE: cinBit = 1'b1;
      CIN_EXT: cinBit = carryIn;
      default: cinBit = 1'b0;
    endcase
    sum    = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, cinBit};
    addOvf = (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);
  end

  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicVal = xOp & yOp;
      LG_OR:   logicVal = xOp | yOp;
      LG_XOR:  logicVal = xOp ^ yOp;
      default: logicVal = ~xOp;
    endcase
  end

  always_comb begin
    case (ctrl.bitOp)
      BT_SET:  bitVal = xOp | ctrl.bitMask;
      BT_CLR:  bitVal = xOp & ~ctrl.bitMask;
      BT_TGL:  bitVal = xOp ^ ctrl.bitMask;
      default: bitVal = xOp & ctrl.bitMask;
    endcase
  end

  // unsigned restoring step: shift in one dividend bit, subtract if it fits
  always_comb begin
    divWide = {xOp, carryIn};
    divGe   = divWide >= {1'b0, yOp};
    divUVal = divGe ? (divWide[WIDTH-1:0] - yOp) : divWide[WIDTH-1:0];
  end

  // signed non-restoring step: signs pick add or subtract
  always_comb begin
    divShift = {xOp[MSB-1:0], carryIn};
    divSVal  = (xOp[MSB] == yOp[MSB]) ? (divShift - yOp) : (divShift + yOp);
    divSQ    = (divSVal[MSB] == yOp[MSB]);
  end

  always_comb begin
    nextC = 1'b0;
    nextV = 1'b0;
    nextQ = 1'b0;
    case (ctrl.resSel)
      SEL_ADDER: begin
        nextVal = sum[WIDTH-1:0];
        nextC   = sum[WIDTH];
        nextV   = addOvf;
      end
      SEL_LOGIC: nextVal = logicVal;
      SEL_BIT:   nextVal = bitVal;
      SEL_DIVU: begin
        nextVal = divUVal;
        nextC   = divGe;
        nextQ   = divGe;
      end
      SEL_DIVS: begin
        nextVal = divSVal;
        nextC   = divSQ;
        nextQ   = divSQ;
      end
      default: nextVal = xOp;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      zeroFlag  <= 1'b0;
      negFlag   <= 1'b0;
      carryFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      quotFlag  <= 1'b0;
    end else begin
      if (ctrl.wrFlags) begin
        zeroFlag  <= (nextVal == '0);
        negFlag   <= nextVal[MSB];
        carryFlag <= nextC;
        ovfFlag   <= nextV;
        quotFlag  <= nextQ;
      end
      if (ctrl.wrResult) begin
        result <= nextVal;
      end
    end
  end

endmodule

// File: rtl/dsp_alu16.sv
module dsp_alu16
  import dsp_alu16_pkg::*;
#(
  parameter int WIDTH = ALU_W,
  localparam int SELW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             noWrite,
  input  logic [3:0]       opCode,
  input  logic [SELW-1:0]  bitSel,
  input  logic [WIDTH-1:0] xOp,
  input  logic [WIDTH-1:0] yOp,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             carryFlag,
  output logic             ovfFlag,
  output logic             quotFlag
);

  alu_ctrl_t ctrl;

  dsp_alu16_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .en      (en),
    .noWrite (noWrite),
    .opCode  (opCode),
    .bitSel  (bitSel),
    .ctrl    (ctrl)
  );

  dsp_alu16_dp #(.WIDTH(WIDTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .xOp       (xOp),
    .yOp       (yOp),
    .carryIn   (carryIn),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .negFlag   (negFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag),
    .quotFlag  (quotFlag)
  );

endmodule

// File: rtl/dsp_alu16_chk.sv
module dsp_alu16_chk
  import dsp_alu16_pkg::*;
#(
  parameter int WIDTH = ALU_W,
  localparam int SELW = $clog2(WIDTH),
  localparam int MSB = WIDTH - 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             en,
  input logic             noWrite,
  input logic [3:0]       opCode,
  input logic [SELW-1:0]  bitSel,
  input logic [WIDTH-1:0] xOp,
  input logic [WIDTH-1:0] yOp,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             negFlag,
  input logic             carryFlag,
  input logic             ovfFlag,
  input logic             quotFlag
);

  logic isLogic;
  assign isLogic = (opCode == OP_AND) || (opCode == OP_OR) ||
                   (opCode == OP_XOR) || (opCode == OP_NOT);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(result) && $stable(zeroFlag) && $stable(negFlag) &&
             $stable(carryFlag) && $stable(ovfFlag) && $stable(quotFlag)));

  p_nowrite_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (en && noWrite) |=> $stable(result));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (en && !noWrite) |=> (zeroFlag == (result == '0)));

  p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (en && !noWrite) |=> (negFlag == result[MSB]));

  p_logic_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (en && isLogic) |=> (!carryFlag && !ovfFlag && !quotFlag));

  p_add_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (en && !noWrite && opCode == OP_ADD) |=>
      (ovfFlag == (($past(xOp[MSB]) == $past(yOp[MSB])) &&
                   (result[MSB] != $past(xOp[MSB])))));

  p_divu_rem_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (en && !noWrite && opCode == OP_DIVU && yOp != '0 && xOp < yOp) |=>
      (result < $past(yOp)));

  p_divu_quot_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (en && opCode == OP_DIVU) |=> (quotFlag == carryFlag));

endmodule

bind dsp_alu16 dsp_alu16_chk #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .en        (en),
  .noWrite   (noWrite),
  .opCode    (opCode),
  .bitSel    (bitSel),
  .xOp       (xOp),
  .yOp       (yOp),
  .carryIn   (carryIn),
  .result    (result),
  .zeroFlag  (zeroFlag),
  .negFlag   (negFlag),
  .carryFlag (carryFlag),
  .ovfFlag   (ovfFlag),
  .quotFlag  (quotFlag)
);

// File: tb/tb_dsp_alu16.sv
`timescale 1ns/1ps
module tb_dsp_alu16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        en, noWrite, carryIn;
  logic [3:0]  opCode, bitSel;
  logic [15:0] xOp, yOp;
  logic [15:0] result;
  logic        zeroFlag, negFlag, carryFlag, ovfFlag, quotFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] expRes;
  logic [4:0]  expFlg;   // {q, v, c, n, z}

  always #2 clk = ~clk;

  dsp_alu16 dut (
    .clk(clk), .rstN(rstN), .en(en), .noWrite(noWrite), .opCode(opCode),
    .bitSel(bitSel), .xOp(xOp), .yOp(yOp), .carryIn(carryIn),
    .result(result), .zeroFlag(zeroFlag), .negFlag(negFlag),
    .carryFlag(carryFlag), .ovfFlag(ovfFlag), .quotFlag(quotFlag)
  );

  // reference: returns {q, v, c, n, z, value}
  function automatic logic [20:0] refModel(logic [3:0] op, logic [15:0] x,
      logic [15:0] y, logic [3:0] b, logic cin);
    logic [16:0] s, w;
    logic [15:0] r, m, t;
    logic c, v, q;
    m = 16'h1 << b;
    c = 1'b0; v = 1'b0; q = 1'b0; r = '0;
    case (op)
      4'd0, 4'd1: begin
        s = {1'b0, x} + {1'b0, y} + ((op == 4'd1) ? {16'd0, cin} : 17'd0);
        r = s[15:0]; c = s[16];
        v = (x[15] == y[15]) && (r[15] != x[15]);
      end
      4'd2, 4'd3: begin
        s = {1'b0, x} + {1'b0, ~y} + ((op == 4'd3) ? {16'd0, cin} : 17'd1);
        r = s[15:0]; c = s[16];
        v = (x[15] != y[15]) && (r[15] != x[15]);
      end
      4'd4: r = x & y;
      4'd5: r = x | y;
      4'd6: r = x ^ y;
      4'd7: r = ~x;
      4'd8: r = x | m;
      4'd9: r = x & ~m;
      4'd10: r = x ^ m;
      4'd11: r = x & m;
      4'd12: begin
        w = {x, cin};
        if (w >= {1'b0, y}) begin
          s = w - {1'b0, y}; r = s[15:0]; q = 1'b1;
        end else r = w[15:0];
        c = q;
      end
      4'd13: begin
        t = {x[14:0], cin};
        r = (x[15] == y[15]) ? (t - y) : (t + y);
        q = (r[15] == y[15]); c = q;
      end
      4'd14: r = x;
      default: begin
        r = 16'd0 - x;
        c = (x == 16'd0);
        v = (x == 16'h8000);
      end
    endcase
    return {q, v, c, r[15], (r == 16'd0), r};
  endfunction

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10, 4'd11: return "R5";
      4'd12: return "R6";
      4'd13: return "R7";
      default: return "R13";
    endcase
  endfunction

  task automatic check(string req, string what, logic [20:0] act, logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs(string req);
    check(req, "result", {5'd0, result}, {5'd0, expRes});
    check(req, "flags{q,v,c,n,z}",
          {16'd0, quotFlag, ovfFlag, carryFlag, negFlag, zeroFlag},
          {16'd0, expFlg});
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic doOp(logic [3:0] op, logic [15:0] x, logic [15:0] y,
      logic [3:0] b, logic cin, logic e, logic nw, string req);
    logic [20:0] m;
    opCode = op; xOp = x; yOp = y; bitSel = b; carryIn = cin;
    en = e; noWrite = nw;
    m = refModel(op, x, y, b, cin);
    if (e) begin
      expFlg = m[20:16];
      if (!nw) expRes = m[15:0];
    end
    @(posedge clk);
    @(negedge clk);
    checkOutputs(req);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [15:0] rem, quo;
    logic [31:0] a32, b32, s32;
    void'($urandom(32'd4242));
    rstN = 1'b0; en = 1'b0; noWrite = 1'b0; carryIn = 1'b0;
    opCode = '0; bitSel = '0; xOp = '0; yOp = '0;
    expRes = '0; expFlg = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOutputs("R1");
    rstN = 1'b1;
    @(negedge clk);

    // R2 add corners
    doOp(4'd0, 16'h7FFF, 16'h0001, 0, 0, 1, 0, "R2");
    doOp(4'd0, 16'hFFFF, 16'h0001, 0, 0, 1, 0, "R2");
    doOp(4'd1, 16'h1234, 16'h0001, 0, 1, 1, 0, "R2");
    doOp(4'd0, 16'h8000, 16'h8000, 0, 0, 1, 0, "R2");
    // R3 subtract corners
    doOp(4'd2, 16'h8000, 16'h0001, 0, 0, 1, 0, "R3");
    doOp(4'd2, 16'h0005, 16'h0005, 0, 0, 1, 0, "R3");
    doOp(4'd2, 16'h0003, 16'h0005, 0, 0, 1, 0, "R3");
    doOp(4'd3, 16'h0005, 16'h0005, 0, 0, 1, 0, "R3");
    // R4 logic
    doOp(4'd4, 16'hF0F0, 16'h0FF0, 0, 0, 1, 0, "R4");
    doOp(4'd7, 16'hFFFF, 16'h0000, 0, 0, 1, 0, "R4");
    // R5 bit ops at both ends
    doOp(4'd8, 16'h0000, 16'h0, 4'd15, 0, 1, 0, "R5");
    doOp(4'd9, 16'hFFFF, 16'h0, 4'd0, 0, 1, 0, "R5");
    doOp(4'd10, 16'h00F0, 16'h0, 4'd4, 0, 1, 0, "R5");
    doOp(4'd11, 16'hFFEF, 16'h0, 4'd4, 0, 1, 0, "R5");
    doOp(4'd11, 16'h0010, 16'h0, 4'd4, 0, 1, 0, "R5");
    // R13 pass and negate corners
    doOp(4'd14, 16'h8001, 16'h0, 0, 1, 1, 0, "R13");
    doOp(4'd15, 16'h8000, 16'h0, 0, 0, 1, 0, "R13");
    doOp(4'd15, 16'h0000, 16'h0, 0, 0, 1, 0, "R13");

    // R9 enable low holds everything
    doOp(4'd0, 16'h1111, 16'h2222, 0, 0, 0, 0, "R9");
    // R10 result-free compare: flags move, result stays
    doOp(4'd2, 16'h0007, 16'h0007, 0, 0, 1, 1, "R10");
    // R8 flags follow unwritten value
    doOp(4'd2, 16'h0000, 16'h0001, 0, 0, 1, 1, "R8");

    // R12 timing: no change before the edge, new value after it
    opCode = 4'd14; xOp = 16'hA5A5; en = 1'b1; noWrite = 1'b0;
    #1;
    check("R12", "before edge", {5'd0, result}, {5'd0, expRes});
    expRes = 16'hA5A5; expFlg = 5'b00010;
    @(posedge clk); #1;
    check("R12", "after edge", {5'd0, result}, {5'd0, expRes});
    @(negedge clk);

    // R11 32-bit add and subtract chains
    for (int k = 0; k < 20; k++) begin
      a32 = $urandom(); b32 = $urandom();
      doOp(4'd0, a32[15:0], b32[15:0], 0, 0, 1, 0, "R11");
      s32[15:0] = result;
      doOp(4'd1, a32[31:16], b32[31:16], 0, carryFlag, 1, 0, "R11");
      s32[31:16] = result;
      check("R11", "add32", {5'd0, s32[31:16]}, {5'd0, 16'((a32 + b32) >> 16)});
      doOp(4'd2, a32[15:0], b32[15:0], 0, 0, 1, 0, "R11");
      s32[15:0] = result;
      doOp(4'd3, a32[31:16], b32[31:16], 0, carryFlag, 1, 0, "R11");
      s32[31:16] = result;
      check("R11", "sub32", {5'd0, s32[31:16]}, {5'd0, 16'((a32 - b32) >> 16)});
    end

    // R6 full unsigned divisions
    for (int k = 0; k < 24; k++) begin
      a32[15:0] = (k == 0) ? 16'hFFFF : 16'($urandom());
      b32[15:0] = (k == 0) ? 16'h0001 : ((k == 1) ? 16'hFFFF : 16'($urandom_range(1, 16'hFFFF)));
      rem = '0; quo = '0;
      for (int i = 15; i >= 0; i--) begin
        doOp(4'd12, rem, b32[15:0], 0, a32[i], 1, 0, "R6");
        rem = result;
        quo = {quo[14:0], quotFlag};
      end
      check("R6", "quotient", {5'd0, quo}, {5'd0, a32[15:0] / b32[15:0]});
      check("R6", "remainder", {5'd0, rem}, {5'd0, a32[15:0] % b32[15:0]});
    end

    // R7 signed steps with chained remainders
    rem = 16'h0003;
    for (int i = 0; i < 16; i++) begin
      doOp(4'd13, rem, 16'hFFF9, 0, i[0], 1, 0, "R7");
      rem = result;
    end

    // random mix of all operations and modes
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      doOp(op, 16'($urandom()), 16'($urandom()), 4'($urandom()),
           1'($urandom()), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 5) == 0), reqOf(op));
    end

    finishRun();
  end

endmodule